// File: doc/BRIEF.md
# Programmable 16x Baud Enable Generator

This block turns one master clock into the timing strobes of a serial port. A 16-bit divisor, loaded by a one-cycle strobe, sets how many master-clock cycles separate two pulses of an oversampling enable. That enable runs at sixteen times the serial bit rate and feeds both the receive sampler and the transmit path. A free-running modulo-16 stage counts those enables and raises a bit-rate tick for the transmitter once every sixteen of them.

Both outputs are one-cycle clock enables in the master clock domain. No derived clock net is produced. Downstream registers stay on the master clock and update only in the cycles where the relevant enable is high. The serial bit rate is therefore the master clock frequency divided by sixteen times the divisor.

Top module: `baud16_gen`

## Requirements
- R1: The divisor is captured only in a cycle where `div_load_i` is high. A change on `div_val_i` without the strobe has no effect on the enable spacing.
- R2: With an effective divisor D, `os_en_o` is high for exactly one cycle in every D master-clock cycles. Any D from 1 to 65535 is valid.
- R3: After a load at clock edge k, `os_en_o` is low following edges k through k+D-1. It then goes high following edges k+D, k+2D and so on. A load restarts the spacing from zero.
- R4: A loaded divisor of 0 behaves exactly like a divisor of 1.
- R5: With an effective divisor of 1, `os_en_o` is high in every cycle that does not follow a load edge.
- R6: `bit_tick_o` is high only together with `os_en_o`, on every sixteenth enable counted since reset. This count is not cleared by a divisor load.
- R7: While `rst_ni` is low, both outputs are low. The enable count restarts from zero, and the divisor returns to the `DIV_RST` parameter value (default 1). On release, the enable spacing starts as if a load of that value had just occurred.
- R8: In steady state, consecutive `bit_tick_o` pulses are 16*D master-clock cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| div_val_i | input | 16 | Divisor value to capture |
| div_load_i | input | 1 | One-cycle strobe that captures `div_val_i` and restarts the divide |
| os_en_o | output | 1 | One-cycle enable at 16x the bit rate |
| bit_tick_o | output | 1 | One-cycle transmit bit-rate tick |

## Verification
The bench targets the divisor values 0 and 1, where a design that forgot the clamp would stall forever on 0 or skip pulses on 1. It reloads the divisor in the middle of a period and also back to back. A design that did not restart the count would emit an early or late enable, or an enable in the load cycle itself. It changes the divisor input without the strobe, which catches a design that reads the port directly. It also checks that the bit tick keeps its sixteen-enable phase across loads and measures the spacing between ticks. This exposes a tick that is cleared on load, off by one enable, or not aligned with an enable. A mid-run reset and the largest divisor complete the set.

// File: rtl/baud16_pkg.sv
package baud16_pkg;
  localparam int unsigned DIV_W_DFLT    = 16;
  localparam int unsigned OS_RATIO_DFLT = 16;

  typedef struct packed {
    logic os_en;
    logic bit_tick;
  } baud_strobe_t;
endpackage

// File: rtl/baud16_div_cnt.sv
module baud16_div_cnt #(
  parameter int unsigned DIV_W   = 16,
  parameter int unsigned DIV_RST = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_val_i,
  input  logic             div_load_i,
  output logic             os_en_o
);
  localparam logic [DIV_W-1:0] ONE_D = DIV_W'(1);
  localparam logic [DIV_W-1:0] RST_D = DIV_W'(DIV_RST);

  logic [DIV_W-1:0] div_q, div_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] eff_div;
  logic             hit;
  logic             en_q, en_d;

  // a zero divisor is clamped to one so the enable never stops
  always_comb begin
    eff_div = (div_q == '0) ? ONE_D : div_q;
    hit     = (cnt_q == eff_div - ONE_D);
  end

  always_comb begin
    div_d = div_q;
    cnt_d = cnt_q;
    en_d  = 1'b0;
    if (div_load_i) begin
      div_d = div_val_i;
      cnt_d = '0;
    end else if (hit) begin
      cnt_d = '0;
      en_d  = 1'b1;
    end else begin
      cnt_d = cnt_q + ONE_D;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= RST_D;
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else begin
      div_q <= div_d;
      cnt_q <= cnt_d;
      en_q  <= en_d;
    end
  end

  assign os_en_o = en_q;

  p_load_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_load_i |=> !os_en_o)
    else $error("p_load_quiet_r3");

  p_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (os_en_o && eff_div > ONE_D && !div_load_i) |=> !os_en_o)
    else $error("p_gap_r2");

  p_div1_every_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_q == ONE_D && !div_load_i) |=> os_en_o)
    else $error("p_div1_every_r5");

  p_zero_as_one_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_q == '0 && !div_load_i) |=> os_en_o)
    else $error("p_zero_as_one_r4");

  p_reset_quiet_r7: assert property (@(posedge clk_i)
    !rst_ni |-> !os_en_o)
    else $error("p_reset_quiet_r7");
endmodule

// File: rtl/baud16_phase.sv
module baud16_phase #(
  parameter int unsigned OS_RATIO = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned PH_W = (OS_RATIO > 1) ? $clog2(OS_RATIO) : 1;
  localparam logic [PH_W-1:0] LAST = PH_W'(OS_RATIO - 1);

  logic [PH_W-1:0] ph_q, ph_d;
  logic            at_last;

  assign at_last = (ph_q == LAST);

  generate
    if ((1 << PH_W) == OS_RATIO) begin : g_pow2
      always_comb ph_d = en_i ? ph_q + PH_W'(1) : ph_q;
    end else begin : g_wrap
      always_comb begin
        ph_d = ph_q;
        if (en_i) ph_d = at_last ? '0 : ph_q + PH_W'(1);
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= '0;
    else         ph_q <= ph_d;
  end

  assign tick_o = en_i && at_last;

  p_tick_needs_en_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> en_i)
    else $error("p_tick_needs_en_r6");

  p_tick_gap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o)
    else $error("p_tick_gap_r6");
endmodule

// File: rtl/baud16_gen.sv
module baud16_gen
  import baud16_pkg::*;
#(
  parameter int unsigned DIV_W    = DIV_W_DFLT,
  parameter int unsigned OS_RATIO = OS_RATIO_DFLT,
  parameter int unsigned DIV_RST  = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_val_i,
  input  logic             div_load_i,
  output logic             os_en_o,
  output logic             bit_tick_o
);
  baud_strobe_t strb;

  baud16_div_cnt #(.DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .div_val_i  (div_val_i),
    .div_load_i (div_load_i),
    .os_en_o    (strb.os_en)
  );

  baud16_phase #(.OS_RATIO(OS_RATIO)) u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (strb.os_en),
    .tick_o (strb.bit_tick)
  );

  assign os_en_o    = strb.os_en;
  assign bit_tick_o = strb.bit_tick;

  p_reset_tick_r7: assert property (@(posedge clk_i)
    !rst_ni |-> !bit_tick_o)
    else $error("p_reset_tick_r7");
endmodule

// File: tb/baud16_gen_tb_top.sv
`timescale 1ns/1ps
module baud16_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] div_val = '0;
  logic        div_load = 1'b0;
  logic        os_en, bit_tick;

  int checks = 0;
  int errors = 0;
  string cur_req = "R7";

  // reference state
  int m_div, m_t, m_cnt;
  bit exp_en, exp_tick;

  always #2 clk = ~clk;

  baud16_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .div_val_i(div_val), .div_load_i(div_load),
    .os_en_o(os_en), .bit_tick_o(bit_tick)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_div = 1; m_t = 0; m_cnt = 0; exp_en = 0; exp_tick = 0;
    end else begin
      if (div_load) begin
        m_div  = (div_val == 0) ? 1 : int'(div_val);
        m_t    = 0;
        exp_en = 0;
      end else begin
        m_t    = m_t + 1;
        exp_en = (m_t % m_div) == 0;
      end
      if (exp_en) m_cnt = m_cnt + 1;
      exp_tick = exp_en && (m_cnt % 16 == 0);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (os_en !== exp_en) begin
        errors++;
        $display("FAIL %s os_en actual %0b expected %0b at %0t", cur_req, os_en, exp_en, $time);
      end
      checks++;
      if (bit_tick !== exp_tick) begin
        errors++;
        $display("FAIL %s/R6 bit_tick actual %0b expected %0b at %0t", cur_req, bit_tick, exp_tick, $time);
      end
    end
  end

  task automatic load(input int v);
    @(negedge clk);
    div_val  = 16'(v);
    div_load = 1'b1;
    @(negedge clk);
    div_load = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_reset_outputs();
    #1;
    checks++;
    if (os_en !== 1'b0 || bit_tick !== 1'b0) begin
      errors++;
      $display("FAIL R7 outputs in reset actual %0b%0b expected 00", os_en, bit_tick);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int last, gap;
    chk_reset_outputs();
    run(3);
    rst_n = 1'b1;
    cur_req = "R5";
    run(40);
    cur_req = "R3";
    load(5);
    run(30);
    cur_req = "R1";
    div_val = 16'd2;
    run(30);
    cur_req = "R4";
    load(0);
    run(40);
    cur_req = "R8";
    load(3);
    last = -1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (bit_tick) begin
        if (last >= 0) begin
          gap = i - last;
          checks++;
          if (gap != 48) begin
            errors++;
            $display("FAIL R8 tick spacing actual %0d expected 48", gap);
          end
        end
        last = i;
      end
    end
    cur_req = "R3";
    load(7);
    run(3);
    load(4);
    run(50);
    load(9);
    load(2);
    load(6);
    run(60);
    cur_req = "R2";
    load(1000);
    run(33000);
    cur_req = "R7";
    @(negedge clk);
    rst_n = 1'b0;
    chk_reset_outputs();
    run(2);
    rst_n = 1'b1;
    run(40);
    cur_req = "R2";
    load(65535);
    run(65600);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule